// File: doc/BRIEF.md
# DMA Completion Tracker with Writeback

This block keeps, for each DMA queue, the completed pointer: a 16-bit ring position meaning that the descriptor at that position and every descriptor before it have delivered their data. The execution engine reports completions in order, one per cycle at most, as a queue index and a descriptor position. An event that moves the pointer to a new in-ring position is accepted. Any other event is dropped.

Each queue has two enables of its own. With writeback on, an accepted completion raises a request to write the pointer, zero-extended to 32 bits, to the 64-bit host address built from that queue's high and low address words. With interrupt on, it raises an interrupt request that carries the queue index. Each request type has its own valid/ready handshake. A request that is still pending is coalesced: it reports the newest pointer and is not issued twice. With both enables off, software reads the status only by polling the pointer. A per-queue reset clears the pointer and drops that queue's pending requests.

Top module: `dma_cpl_tracker`

## Requirements
- R1: After the global reset, every completed pointer is 0 and neither wb_valid nor irq_valid is asserted.
- R2: An accepted event for queue q sets q's completed pointer to cpl_pos on the next clock edge. The pointer changes at no other time, except on a queue reset.
- R3: An event whose position equals the queue's current pointer is ignored. The pointer does not change and no request is raised.
- R4: The 5-bit size field of a queue gives a ring depth of 2^size for values 1 to 16. Any other value is treated as 1, a depth of 2. An event with a position at or above the depth is ignored.
- R5: With writeback enabled, an accepted event makes wb_valid rise one cycle later. It carries wb_qid = q, wb_addr = {addr_hi, addr_lo} of q, and wb_data = the current pointer of q in bits 15:0 with zeros above.
- R6: With interrupt enabled, an accepted event makes irq_valid rise one cycle later, with irq_qid = q.
- R7: Further accepted events on a queue that already has a pending request update the payload to the newest pointer. They never produce a second request for that queue.
- R8: A pending request stays asserted until valid and ready are both high, and is removed on that edge. If an accepted event for the same queue and type arrives in that same cycle, the request stays pending.
- R9: When several queues have a pending request of one type, the lowest queue index is presented first. Writeback and interrupt are arbitrated independently.
- R10: A queue reset pulse clears that queue's pointer and its pending writeback and interrupt requests on the next edge. It takes precedence over a completion for the same queue in the same cycle.
- R11: With an enable off, accepted events still move the pointer but raise no request of that type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wb_en | input | NQ | Per-queue writeback enable |
| cfg_irq_en | input | NQ | Per-queue interrupt enable |
| cfg_ring_log2 | input | 5*NQ | Per-queue ring size exponent |
| cfg_wb_addr_lo | input | 32*NQ | Per-queue writeback address, low word |
| cfg_wb_addr_hi | input | 32*NQ | Per-queue writeback address, high word |
| q_reset | input | NQ | Per-queue reset pulse |
| cpl_valid | input | 1 | Completion event strobe |
| cpl_qid | input | QW | Completion queue index |
| cpl_pos | input | 16 | Completed descriptor position |
| cmpl_ptr | output | 16*NQ | Completed pointers, queue q at bits 16q+15:16q |
| wb_valid | output | 1 | Writeback request valid |
| wb_ready | input | 1 | Writeback request accepted |
| wb_qid | output | QW | Queue of the writeback request |
| wb_addr | output | 64 | Host address of the writeback |
| wb_data | output | 32 | Writeback payload |
| irq_valid | output | 1 | Interrupt request valid |
| irq_ready | input | 1 | Interrupt request accepted |
| irq_qid | output | QW | Queue of the interrupt request |

## Verification
The bench targets several corner cases, and each one catches a distinct fault:
- Positions just past the ring depth, and illegal size codes. A tracker that masks the position instead of rejecting it would advance to a wrong slot.
- Repeated positions. Treating a repeat as progress would fire a needless writeback.
- Events that land while a request waits with ready low. A design that queues them would show a duplicate request; one that latches the payload would write back a stale pointer.
- A completion in the handshake cycle. Losing it would drop a notification.
- A queue reset together with a completion. Letting the completion win would leave a stale pointer and request behind.
- Randomized traffic with ready toggling, checked every cycle against the model. This exposes a wrong arbitration order.

// File: rtl/dma_cpl_tracker.sv
module dma_cpl_tracker #(
  parameter int NQ = 4,
  parameter int PW = 16,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int SW = $clog2(PW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    cfg_wb_en,
  input  logic [NQ-1:0]    cfg_irq_en,
  input  logic [NQ*SW-1:0] cfg_ring_log2,
  input  logic [NQ*32-1:0] cfg_wb_addr_lo,
  input  logic [NQ*32-1:0] cfg_wb_addr_hi,
  input  logic [NQ-1:0]    q_reset,
  input  logic             cpl_valid,
  input  logic [QW-1:0]    cpl_qid,
  input  logic [PW-1:0]    cpl_pos,
  output logic [NQ*PW-1:0] cmpl_ptr,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [QW-1:0]    wb_qid,
  output logic [63:0]      wb_addr,
  output logic [31:0]      wb_data,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [QW-1:0]    irq_qid
);

  logic [PW-1:0] ptr_q [NQ];
  logic [NQ-1:0] wb_pend, irq_pend, hit;
  logic [QW-1:0] wb_sel, irq_sel;

  always_comb begin
    wb_sel  = '0;
    irq_sel = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (wb_pend[i])  wb_sel  = QW'(i);
      if (irq_pend[i]) irq_sel = QW'(i);
    end
  end

  assign wb_valid  = |wb_pend;
  assign irq_valid = |irq_pend;
  assign wb_qid    = wb_sel;
  assign irq_qid   = irq_sel;
  assign wb_addr   = {cfg_wb_addr_hi[wb_sel*32 +: 32], cfg_wb_addr_lo[wb_sel*32 +: 32]};
  assign wb_data   = {{(32-PW){1'b0}}, ptr_q[wb_sel]};

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [SW-1:0] raw_lg, lg;
    logic [PW:0]   span;
    logic [PW-1:0] mask;
    logic          wb_take, irq_take;

    assign raw_lg   = cfg_ring_log2[q*SW +: SW];
    assign lg       = (raw_lg >= SW'(1) && raw_lg <= SW'(PW)) ? raw_lg : SW'(1);
    assign span     = ({{PW{1'b0}}, 1'b1} << lg) - 1'b1;
    assign mask     = span[PW-1:0];
    assign hit[q]   = cpl_valid && cpl_qid == QW'(q) && (cpl_pos & ~mask) == '0
                      && cpl_pos != ptr_q[q];
    assign wb_take  = wb_ready && wb_pend[q] && wb_sel == QW'(q);
    assign irq_take = irq_ready && irq_pend[q] && irq_sel == QW'(q);
    assign cmpl_ptr[q*PW +: PW] = ptr_q[q];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[q]    <= '0;
        wb_pend[q]  <= 1'b0;
        irq_pend[q] <= 1'b0;
      end else if (q_reset[q]) begin
        ptr_q[q]    <= '0;
        wb_pend[q]  <= 1'b0;
        irq_pend[q] <= 1'b0;
      end else begin
        if (hit[q]) ptr_q[q] <= cpl_pos;
        wb_pend[q]  <= (wb_pend[q] && !wb_take) || (hit[q] && cfg_wb_en[q]);
        irq_pend[q] <= (irq_pend[q] && !irq_take) || (hit[q] && cfg_irq_en[q]);
      end
    end
  end

endmodule

// File: rtl/dma_cpl_tracker_chk.sv
module dma_cpl_tracker_chk #(
  parameter int NQ = 4,
  parameter int PW = 16,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NQ-1:0]    q_reset,
  input logic             cpl_valid,
  input logic [QW-1:0]    cpl_qid,
  input logic [PW-1:0]    cpl_pos,
  input logic [NQ*PW-1:0] cmpl_ptr,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [QW-1:0]    wb_qid,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [QW-1:0]    irq_qid
);

  for (genvar q = 0; q < NQ; q++) begin : g_chk
    // R10
    qreset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_reset[q] |=> cmpl_ptr[q*PW +: PW] == '0);

    // R2
    ptr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmpl_ptr[q*PW +: PW]) |->
        $past(q_reset[q] || (cpl_valid && cpl_qid == QW'(q))));

    // R3
    repeat_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_qid == QW'(q) && cpl_pos == cmpl_ptr[q*PW +: PW] && !q_reset[q])
        |=> $stable(cmpl_ptr[q*PW +: PW]));
  end

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready && !q_reset[wb_qid]) |=> wb_valid);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !q_reset[irq_qid]) |=> irq_valid);

endmodule

bind dma_cpl_tracker dma_cpl_tracker_chk #(.NQ(NQ), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_reset(q_reset), .cpl_valid(cpl_valid),
  .cpl_qid(cpl_qid), .cpl_pos(cpl_pos), .cmpl_ptr(cmpl_ptr),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_qid(wb_qid),
  .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_qid(irq_qid)
);

// File: tb/test_dma_cpl_tracker.sv
module test_dma_cpl_tracker;
  localparam int NQ = 4;
  localparam int QW = 2;

  logic clk = 0, rst_n = 0;
  logic [NQ-1:0] wb_en = 0, irq_en = 0, qrst = 0;
  logic [NQ*5-1:0] lg2 = 0;
  logic [NQ*32-1:0] alo, ahi;
  logic cpl_valid = 0, wb_ready = 0, irq_ready = 0;
  logic [QW-1:0] cpl_qid = 0;
  logic [15:0] cpl_pos = 0;
  logic [NQ*16-1:0] cmpl_ptr;
  logic wb_valid, irq_valid;
  logic [QW-1:0] wb_qid, irq_qid;
  logic [63:0] wb_addr;
  logic [31:0] wb_data;

  int checks = 0, errors = 0;
  int mptr [NQ];
  bit mwp [NQ];
  bit mip [NQ];

  always #10 clk = ~clk;

  dma_cpl_tracker i_dma_cpl_tracker (
    .clk(clk), .rst_n(rst_n), .cfg_wb_en(wb_en), .cfg_irq_en(irq_en),
    .cfg_ring_log2(lg2), .cfg_wb_addr_lo(alo), .cfg_wb_addr_hi(ahi),
    .q_reset(qrst), .cpl_valid(cpl_valid), .cpl_qid(cpl_qid), .cpl_pos(cpl_pos),
    .cmpl_ptr(cmpl_ptr), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_qid(wb_qid),
    .wb_addr(wb_addr), .wb_data(wb_data), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_qid(irq_qid)
  );

  function automatic int lowest(bit isw);
    for (int q = 0; q < NQ; q++) if (isw ? mwp[q] : mip[q]) return q;
    return -1;
  endfunction

  task automatic chk(string rq, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic compare();
    int ws, is;
    ws = lowest(1);
    is = lowest(0);
    for (int q = 0; q < NQ; q++) chk("R2", "ptr", cmpl_ptr[q*16 +: 16], mptr[q]);
    chk("R5", "wb_valid", wb_valid, ws >= 0);
    chk("R6", "irq_valid", irq_valid, is >= 0);
    if (ws >= 0) begin
      chk("R9", "wb_qid", wb_qid, ws);
      chk("R5", "wb_addr", wb_addr, {ahi[ws*32 +: 32], alo[ws*32 +: 32]});
      chk("R7", "wb_data", wb_data, mptr[ws]);
    end
    if (is >= 0) chk("R9", "irq_qid", irq_qid, is);
  endtask

  task automatic step();
    int ws, is, s, depth;
    bit hit;
    ws = lowest(1);
    is = lowest(0);
    for (int q = 0; q < NQ; q++) begin
      s = lg2[q*5 +: 5];
      if (s < 1 || s > 16) s = 1;   // R4
      depth = 1 << s;
      hit = cpl_valid && cpl_qid == q && cpl_pos < depth && cpl_pos != mptr[q];
      if (qrst[q]) begin            // R10
        mptr[q] = 0; mwp[q] = 0; mip[q] = 0;
      end else begin
        if (hit) mptr[q] = cpl_pos;
        mwp[q] = (mwp[q] && !(wb_ready && ws == q)) || (hit && wb_en[q]);
        mip[q] = (mip[q] && !(irq_ready && is == q)) || (hit && irq_en[q]);
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
    cpl_valid = 0;
    qrst = 0;
  endtask

  task automatic ev(int q, int pos);
    cpl_valid = 1; cpl_qid = QW'(q); cpl_pos = 16'(pos);
    step();
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin
      alo[q*32 +: 32] = 32'h1000_0000 + 32'(q * 64);
      ahi[q*32 +: 32] = 32'hA000_0000 + 32'(q);
      mptr[q] = 0; mwp[q] = 0; mip[q] = 0;
    end
    lg2 = {5'd16, 5'd3, 5'd0, 5'd3};
    repeat (3) @(negedge clk);
    compare();                          // R1
    rst_n = 1;
    @(negedge clk);
    // R2 / R4
    ev(0, 5); ev(0, 8); ev(0, 7);
    ev(1, 2); ev(1, 1);                 // R4 illegal size -> depth 2
    ev(3, 16'hFFFF);
    // R3
    ev(0, 7); step();
    // R11 disabled enables: pointer only
    ev(2, 4);
    // R5 / R7 / R8
    wb_en = 4'b1111; irq_en = 4'b0101;
    ev(2, 6); ev(2, 1); ev(2, 3); step();
    // R9
    ev(0, 1); ev(1, 0); step();
    wb_ready = 1; irq_ready = 1; step();
    // R8 same-cycle re-arm
    wb_ready = 0; irq_ready = 0;
    ev(0, 2);
    wb_ready = 1; ev(0, 3); wb_ready = 0; step();
    // R10 reset beats completion
    ev(2, 5);
    qrst = 4'b0100; ev(2, 7); step();
    wb_ready = 1; irq_ready = 1; step(); step(); step();
    // R6 irq-only
    wb_en = 0; irq_en = 4'b1010; ev(3, 9); step();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int q;
      q = $urandom_range(NQ - 1);
      if ($urandom_range(9) == 0) lg2[q*5 +: 5] = 5'($urandom_range(17));
      if ($urandom_range(15) == 0) wb_en = 4'($urandom);
      if ($urandom_range(15) == 0) irq_en = 4'($urandom);
      wb_ready = $urandom_range(2) != 0;
      irq_ready = $urandom_range(3) == 0;
      if ($urandom_range(40) == 0) qrst = 4'($urandom);
      cpl_valid = $urandom_range(1);
      cpl_qid = QW'(q);
      cpl_pos = $urandom_range(3) == 0 ? 16'($urandom_range(40))
                                       : 16'(mptr[q] + $urandom_range(3));
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule